// File: doc/BRIEF.md
# Bus Break Symbol Generator

This block forces a break symbol onto the transmit pin of a variable-pulse-width serial bus. The normal symbol encoder feeds its pin level through the block. When software issues a send-break strobe, the block takes over the pin at once. It holds the dominant level for a programmed duration and, for as long as the break lasts, tells the normal transmitter that it has been overridden. Nothing in flight delays the break and nothing can mask it.

The duration is counted in timing ticks. Its nominal length is `TV5_TICKS` ticks. When the high-speed (quad-rate) mode is selected at the strobe, the length becomes `MULT * TV5_TICKS` ticks, so that slower nodes still see a break. The break ends in one of two ways: the duration expires, or the enable input is dropped. There is no cancel path. A fresh strobe during a break starts the count again from zero.

Top module: `vpw_break_gen`

## Requirements
- R1: After reset `brk_active_o` and `tx_override_o` are 0, and `tx_pin_o` equals `tx_data_i`.
- R2: A cycle with `brk_req_i`=1 and `enable_i`=1 starts a break. `brk_active_o` and `tx_override_o` are 1, and `tx_pin_o` is dominant (1), from the clock edge that samples the strobe. This holds whatever the normal transmitter is doing.
- R3: While a break is active, `tx_pin_o` stays 1 and `tx_override_o` stays 1 whatever `tx_data_i` does. When no break is active, `tx_pin_o` follows `tx_data_i` and `tx_override_o` is 0.
- R4: With `quad_mode_i`=0 at the strobe, the break ends on the edge that sees its `TV5_TICKS`-th tick. With a tick on every cycle, `brk_active_o` is therefore high for exactly `TV5_TICKS` cycles (300 by default).
- R5: With `quad_mode_i`=1 at the strobe, the break lasts `MULT*TV5_TICKS` ticks (1200 by default). The mode is captured at the strobe, and later changes to `quad_mode_i` have no effect on a running break.
- R6: In the cycle where the break ends, `brk_active_o` and `tx_override_o` fall together, and `tx_pin_o` returns to `tx_data_i`.
- R7: `enable_i`=0 ends an active break on the next clock edge. A strobe seen while `enable_i`=0 starts no break.
- R8: A strobe during an active break resets the tick count. The break then ends `TV5_TICKS` ticks after that second strobe.
- R9: Ticks are the only way to advance the count. With no ticks, a break lasts until `enable_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_req_i | input | 1 | Send-break strobe, one cycle |
| enable_i | input | 1 | Block enable; low aborts a break |
| quad_mode_i | input | 1 | High-speed mode, captured at strobe |
| tick_i | input | 1 | Timing tick, one cycle per time unit |
| tx_data_i | input | 1 | Pin level from the normal symbol encoder |
| tx_pin_o | output | 1 | Bus transmit pin level, 1 = dominant |
| brk_active_o | output | 1 | Break in progress |
| tx_override_o | output | 1 | Forces the normal transmitter off |

## Verification
All outputs of the block are registered one stage behind the strobe. The break flag and the dominant pin therefore appear on the edge that samples the strobe. The break ends on the edge that counts the last tick, and it ends one edge after `enable_i` is seen low.

The driver places each expected pulse length in a queue. These lengths are `TV5_TICKS`, `MULT*TV5_TICKS`, the restart distance plus `TV5_TICKS`, and the abort distance. The monitor samples on falling clock edges, where every registered output is settled. It counts the cycles the flag is high and compares each finished pulse with the head of the queue. The monitor also checks the pin level in the cycle the flag falls. Direct checks cover the pin pass-through, the masking of the normal transmitter and the ignored strobe.

// File: rtl/vpw_brk_pkg.sv
package vpw_brk_pkg;
  localparam logic PIN_DOMINANT = 1'b1;

  function automatic int unsigned brk_len(input int unsigned tv5, input int unsigned mult,
                                          input bit quad);
    return quad ? tv5 * mult : tv5;
  endfunction
endpackage

// File: rtl/brk_mode_latch.sv
module brk_mode_latch #(
  parameter int unsigned TV5_TICKS = 300,
  parameter int unsigned MULT      = 4,
  localparam int unsigned LIM_W    = $clog2(MULT * TV5_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             quad_i,
  output logic [LIM_W-1:0] limit_o
);
  import vpw_brk_pkg::*;

  localparam logic [LIM_W-1:0] LIM_NORM = LIM_W'(brk_len(TV5_TICKS, MULT, 1'b0));
  localparam logic [LIM_W-1:0] LIM_QUAD = LIM_W'(brk_len(TV5_TICKS, MULT, 1'b1));

  logic quad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      quad_q <= 1'b0;
    else if (start_i) quad_q <= quad_i;
  end

  assign limit_o = quad_q ? LIM_QUAD : LIM_NORM;

  // R5: mode only moves at a strobe
  p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(quad_q));
endmodule

// File: rtl/brk_timer.sv
module brk_timer #(
  parameter int unsigned TV5_TICKS = 300,
  parameter int unsigned MULT      = 4,
  localparam int unsigned LIM_W    = $clog2(MULT * TV5_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             active_o
);
  localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

  logic             active_q;
  logic [LIM_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = tick_i && (cnt_q == limit_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (req_i) begin
      active_q <= 1'b1;   // restart on any strobe
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (last_tick) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + ONE;
      end
    end
  end

  assign active_o = active_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i) |=> active_q);
  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && req_i && en_i) |=> (cnt_q == '0));
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < limit_i));
  p_no_tick_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && en_i && !req_i && !tick_i) |=> (active_q && $stable(cnt_q)));
endmodule

// File: rtl/brk_pin_mux.sv
module brk_pin_mux (
  input  logic brk_i,
  input  logic tx_data_i,
  output logic pin_o,
  output logic override_o
);
  import vpw_brk_pkg::*;

  assign pin_o      = brk_i ? PIN_DOMINANT : tx_data_i;
  assign override_o = brk_i;
endmodule

// File: rtl/vpw_break_gen.sv
module vpw_break_gen #(
  parameter int unsigned TV5_TICKS = 300,
  parameter int unsigned MULT      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_req_i,
  input  logic enable_i,
  input  logic quad_mode_i,
  input  logic tick_i,
  input  logic tx_data_i,
  output logic tx_pin_o,
  output logic brk_active_o,
  output logic tx_override_o
);
  import vpw_brk_pkg::*;

  localparam int unsigned LIM_W = $clog2(MULT * TV5_TICKS + 1);

  logic             start;
  logic [LIM_W-1:0] limit;
  logic             active;

  assign start = brk_req_i && enable_i;

  brk_mode_latch #(.TV5_TICKS(TV5_TICKS), .MULT(MULT)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .quad_i  (quad_mode_i),
    .limit_o (limit)
  );

  brk_timer #(.TV5_TICKS(TV5_TICKS), .MULT(MULT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (brk_req_i),
    .en_i     (enable_i),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .active_o (active)
  );

  brk_pin_mux u_mux (
    .brk_i      (active),
    .tx_data_i  (tx_data_i),
    .pin_o      (tx_pin_o),
    .override_o (tx_override_o)
  );

  assign brk_active_o = active;

  p_pin_dom_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_active_o |-> (tx_pin_o == PIN_DOMINANT && tx_override_o));
  p_end_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_active_o) |-> (!tx_override_o && tx_pin_o == tx_data_i));
  p_strobe_to_pin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (tx_pin_o == PIN_DOMINANT));
endmodule

// File: tb/vpw_break_gen_test.sv
module vpw_break_gen_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TV5 = 300;
  localparam int  MUL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, en = 1'b1, quad = 1'b0, tick_en = 1'b1, txd = 1'b0;
  logic pin, act, ovr;

  int checks = 0, failures = 0;
  int    exp_len[$];
  string exp_tag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vpw_break_gen #(.TV5_TICKS(TV5), .MULT(MUL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .brk_req_i(req), .enable_i(en),
    .quad_mode_i(quad), .tick_i(tick_en), .tx_data_i(txd),
    .tx_pin_o(pin), .brk_active_o(act), .tx_override_o(ovr)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic push(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  // strobe presented at next negedge, returns one negedge later
  task automatic strobe();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic wait_idle();
    while (act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: measures every break pulse, compares with queue
  int  run = 0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (act) run = prev ? run + 1 : 1;
      else if (prev) begin
        chk("R6 pin released at end", int'(pin), int'(txd));
        chk("R6 override released at end", int'(ovr), 0);
        if (exp_len.size() == 0) chk("unexpected pulse", run, -1);
        else begin
          string t;
          int    e;
          t = exp_tag.pop_front();
          e = exp_len.pop_front();
          chk(t, run, e);
        end
      end
      prev = act;
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active after reset", int'(act), 0);
        chk("R1 override after reset", int'(ovr), 0);
        chk("R1 pin follows tx low", int'(pin), 0);
        txd = 1'b1;
        #1 chk("R3 pin follows tx high", int'(pin), 1);
        txd = 1'b0;

        // normal-mode break with transmitter toggling
        push(TV5, "R4 normal length");
        strobe();
        chk("R2 active after strobe", int'(act), 1);
        chk("R2 pin dominant", int'(pin), 1);
        chk("R3 override during break", int'(ovr), 1);
        txd = 1'b1;
        @(negedge clk) txd = 1'b0;
        chk("R3 tx masked during break", int'(pin), 1);
        wait_idle();

        // quad mode, deasserted right after capture
        quad = 1'b1;
        push(TV5 * MUL, "R5 quad length");
        @(negedge clk) req = 1'b1;
        @(negedge clk) begin req = 1'b0; quad = 1'b0; end
        wait_idle();

        // normal mode, quad raised mid-break has no effect
        push(TV5, "R5 mode captured at strobe");
        strobe();
        repeat (10) @(negedge clk);
        quad = 1'b1;
        wait_idle();
        quad = 1'b0;

        // restart 100 cycles in
        push(100 + TV5, "R8 restart");
        strobe();
        repeat (98) @(negedge clk);
        strobe();
        wait_idle();

        // enable abort after 50 cycles
        push(50, "R7 enable abort");
        strobe();
        repeat (49) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R7 inactive after enable low", int'(act), 0);
        // strobe while disabled
        strobe();
        repeat (3) @(negedge clk);
        chk("R7 strobe ignored when disabled", int'(act), 0);
        en = 1'b1;
        repeat (3) @(negedge clk);

        // no ticks: break holds until enable drops
        tick_en = 1'b0;
        push(2000, "R9 hold without ticks");
        strobe();
        repeat (1999) @(negedge clk);
        chk("R9 still active without ticks", int'(act), 1);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);

        chk("queue drained", exp_len.size(), 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule